// File: doc/BRIEF.md
# VGA Segment-Digit Overlay Renderer

This block decides the colour of every pixel on a 640x480 VGA raster. A separate sync generator supplies the current column and row counts; the renderer answers with a 12-bit colour (4 bits each of red, green and blue), one pixel clock later. It draws a row of decimal digits in a seven-bar style, a small stored emblem near the bottom of the screen, and a flat background everywhere else.

Each digit is a separate instance with its own 4-bit value and a fixed horizontal position set by parameter. An instance does not read a glyph bitmap. Instead it tests the pixel against seven bar rectangles and keeps only the bars that its value lights. Each instance raises a hit flag, and the flags are ORed together. The emblem is a 16x16 stored bit pattern, and each bit is drawn as a 2x2 pixel block. Any digit hit or lit emblem pixel takes the foreground colour.

Top module: `vga_digit_overlay`

## Requirements
- R1: While `rst_n` is low, `rgb` is 12'h000.
- R2: `rgb` is registered. The colour seen after a rising clock edge belongs to the `px_x`/`px_y`/`digit_val` values present at that edge.
- R3: When `px_x` >= 640 or `px_y` >= 480, `rgb` is 12'h000, whatever the digits or emblem would give.
- R4: Digit k (k = 0, 1, 2) uses `digit_val[4k+3:4k]`. It occupies a 100x160 cell whose top-left corner is at column 106*k and row 60. Digit 0 is leftmost.
- R5: In cell-local coordinates (lx, ly), the seven bars are: top ly<16; upper-right lx>=84 and ly<80; lower-right lx>=84 and ly>=80; bottom ly>=144; lower-left lx<16 and ly>=80; upper-left lx<16 and ly<80; middle 72<=ly<88. Values light bars as follows: 0 all but middle; 1 the two right bars; 2 top, upper-right, middle, lower-left, bottom; 3 top, both right, middle, bottom; 4 upper-left, middle, both right; 5 top, upper-left, middle, lower-right, bottom; 6 all but upper-right; 7 top and both right; 8 all; 9 all but lower-left.
- R6: Values 10 to 15 light no bar, so the digit's whole cell shows the background.
- R7: An active pixel inside a lit bar of any digit is drawn in the foreground colour 12'hFA0.
- R8: The emblem covers columns 304..335 and rows 432..463. Pixel (x, y) there maps to pattern row r=(y-432)/2 and column c=(x-304)/2. It is lit, in the foreground colour 12'hFA0, when bit 2 of r equals bit 2 of c.
- R9: Every other active pixel is drawn in the background colour 12'h113.
- R10: A digit's output depends only on its own value nibble. Changing the other nibbles does not alter the pixels in its cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_x | input | 10 | Current column count from the sync generator (0..799) |
| px_y | input | 10 | Current row count from the sync generator |
| digit_val | input | 12 | Three 4-bit digit values, digit 0 in bits 3:0 |
| rgb | output | 12 | Registered pixel colour {red, green, blue} |

## Verification
The block's only state is the colour register. A fault in it shows on the very next pixel as a wrong colour at one exact column and row. A mis-sized bar rectangle or a wrong value-to-bar entry appears as a one-pixel-wide error at a bar edge. The bench therefore walks rows placed just either side of every bar boundary, and checks every pixel one clock after it is presented. An offset or latency error shifts the whole image by a column and fails on the first edge pixel it reaches.

// File: rtl/vga_ovl_pkg.sv
package vga_ovl_pkg;

    localparam int COLOR_W = 12;

    typedef logic [COLOR_W-1:0] color_t;

    // bit 0 top, 1 upper-right, 2 lower-right, 3 bottom,
    // 4 lower-left, 5 upper-left, 6 middle
    typedef logic [6:0] bar_set_t;

    typedef struct packed {
        color_t rgb;
    } pix_state_t;

    function automatic bar_set_t bars_for_value(input logic [3:0] v);
        bar_set_t m;
        case (v)
            4'd0:    m = 7'h3F;
            4'd1:    m = 7'h06;
            4'd2:    m = 7'h5B;
            4'd3:    m = 7'h4F;
            4'd4:    m = 7'h66;
            4'd5:    m = 7'h6D;
            4'd6:    m = 7'h7D;
            4'd7:    m = 7'h07;
            4'd8:    m = 7'h7F;
            4'd9:    m = 7'h6F;
            default: m = 7'h00;
        endcase
        return m;
    endfunction

    // emblem pattern: lit where bit 2 of row equals bit 2 of column
    function automatic logic [31:0] emblem_row(input int r);
        logic [31:0] row;
        for (int c = 0; c < 32; c++) begin
            row[c] = (((r >> 2) & 1) == ((c >> 2) & 1));
        end
        return row;
    endfunction

endpackage

// File: rtl/vga_seg_digit.sv
module vga_seg_digit
    import vga_ovl_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int ORIGIN_X = 0,
    parameter int ORIGIN_Y = 60,
    parameter int CELL_W = 100,
    parameter int CELL_H = 160,
    parameter int STROKE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] px_x,
    input  logic [COORD_W-1:0] px_y,
    input  logic [3:0]         value,
    output logic               hit
);

    localparam int HALF_Y  = CELL_H / 2;
    localparam int MID_LO  = HALF_Y - STROKE / 2;
    localparam int MID_HI  = HALF_Y + STROKE / 2;
    localparam int RIGHT_X = CELL_W - STROKE;
    localparam int BOT_Y   = CELL_H - STROKE;

    int       lx;
    int       ly;
    logic     in_cell;
    bar_set_t area;
    bar_set_t lit;

    always_comb begin
        lx      = int'(px_x) - ORIGIN_X;
        ly      = int'(px_y) - ORIGIN_Y;
        in_cell = (lx >= 0) && (lx < CELL_W) && (ly >= 0) && (ly < CELL_H);

        area[0] = in_cell && (ly < STROKE);
        area[1] = in_cell && (lx >= RIGHT_X) && (ly < HALF_Y);
        area[2] = in_cell && (lx >= RIGHT_X) && (ly >= HALF_Y);
        area[3] = in_cell && (ly >= BOT_Y);
        area[4] = in_cell && (lx < STROKE) && (ly >= HALF_Y);
        area[5] = in_cell && (lx < STROKE) && (ly < HALF_Y);
        area[6] = in_cell && (ly >= MID_LO) && (ly < MID_HI);

        lit = bars_for_value(value);
        hit = |(area & lit);
    end

    // values above nine never light anything
    p_blank_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (value > 4'd9) |-> !hit);

    // a one only ever lights pixels on the right-hand bars
    p_one_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((value == 4'd1) && hit) |-> (lx >= RIGHT_X));

    // the upper hollow of the cell is never lit for any value
    p_upper_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lx >= STROKE) && (lx < RIGHT_X) && (ly >= STROKE) && (ly < MID_LO)) |-> !hit);

endmodule

// File: rtl/vga_emblem_rom.sv
module vga_emblem_rom
    import vga_ovl_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int BASE_X = 304,
    parameter int BASE_Y = 432,
    parameter int DOTS = 16,
    parameter int SCALE = 2
) (
    input  logic [COORD_W-1:0] px_x,
    input  logic [COORD_W-1:0] px_y,
    output logic               hit
);

    localparam int SPAN  = DOTS * SCALE;
    localparam int IDX_W = $clog2(DOTS);

    logic [DOTS-1:0] store [DOTS];

    for (genvar g = 0; g < DOTS; g++) begin : g_row
        assign store[g] = DOTS'(emblem_row(g));
    end

    int               dx;
    int               dy;
    logic             in_box;
    logic [IDX_W-1:0] r_idx;
    logic [IDX_W-1:0] c_idx;

    always_comb begin
        dx     = int'(px_x) - BASE_X;
        dy     = int'(px_y) - BASE_Y;
        in_box = (dx >= 0) && (dx < SPAN) && (dy >= 0) && (dy < SPAN);
        r_idx  = IDX_W'(dy / SCALE);
        c_idx  = IDX_W'(dx / SCALE);
        hit    = in_box && store[r_idx][c_idx];
    end

endmodule

// File: rtl/vga_digit_overlay.sv
module vga_digit_overlay
    import vga_ovl_pkg::*;
#(
    parameter int     COORD_W     = 10,
    parameter int     H_ACTIVE    = 640,
    parameter int     V_ACTIVE    = 480,
    parameter int     NUM_DIGITS  = 3,
    parameter int     DIGIT_X0    = 0,
    parameter int     DIGIT_PITCH = 106,
    parameter int     DIGIT_TOP   = 60,
    parameter int     CELL_W      = 100,
    parameter int     CELL_H      = 160,
    parameter int     STROKE      = 16,
    parameter int     EMB_X       = 304,
    parameter int     EMB_Y       = 432,
    parameter int     EMB_DOTS    = 16,
    parameter int     EMB_SCALE   = 2,
    parameter color_t FG_COLOR    = 12'hFA0,
    parameter color_t BG_COLOR    = 12'h113
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      px_x,
    input  logic [COORD_W-1:0]      px_y,
    input  logic [NUM_DIGITS*4-1:0] digit_val,
    output logic [COLOR_W-1:0]      rgb
);

    logic [NUM_DIGITS-1:0] digit_hit;
    logic                  any_digit;
    logic                  emblem_hit;
    logic                  active;
    pix_state_t            pix_d;
    pix_state_t            pix_q;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        vga_seg_digit #(
            .COORD_W (COORD_W),
            .ORIGIN_X(DIGIT_X0 + k * DIGIT_PITCH),
            .ORIGIN_Y(DIGIT_TOP),
            .CELL_W  (CELL_W),
            .CELL_H  (CELL_H),
            .STROKE  (STROKE)
        ) digit_i (
            .clk  (clk),
            .rst_n(rst_n),
            .px_x (px_x),
            .px_y (px_y),
            .value(digit_val[k*4 +: 4]),
            .hit  (digit_hit[k])
        );
    end

    vga_emblem_rom #(
        .COORD_W(COORD_W),
        .BASE_X (EMB_X),
        .BASE_Y (EMB_Y),
        .DOTS   (EMB_DOTS),
        .SCALE  (EMB_SCALE)
    ) emblem_i (
        .px_x(px_x),
        .px_y(px_y),
        .hit (emblem_hit)
    );

    always_comb begin
        any_digit = |digit_hit;
        active    = (int'(px_x) < H_ACTIVE) && (int'(px_y) < V_ACTIVE);
        pix_d     = pix_q;
        if (!active) begin
            pix_d.rgb = '0;
        end else if (any_digit || emblem_hit) begin
            pix_d.rgb = FG_COLOR;
        end else begin
            pix_d.rgb = BG_COLOR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign rgb = pix_q.rgb;

    p_dark_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (rgb == '0));

    p_digit_fg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && any_digit) |=> (rgb == FG_COLOR));

    p_emblem_fg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && emblem_hit) |=> (rgb == FG_COLOR));

    p_backdrop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !any_digit && !emblem_hit) |=> (rgb == BG_COLOR));

endmodule

// File: tb/vga_digit_overlay_tb_top.sv
module vga_digit_overlay_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  px_x = '0;
    logic [9:0]  px_y = '0;
    logic [11:0] digit_val = '0;
    logic [11:0] rgb;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [11:0] pend_exp;
    string       pend_tag;
    bit          have_pend = 0;

    localparam logic [11:0] FG = 12'hFA0;
    localparam logic [11:0] BG = 12'h113;

    always #5 clk = ~clk;

    vga_digit_overlay dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .px_x     (px_x),
        .px_y     (px_y),
        .digit_val(digit_val),
        .rgb      (rgb)
    );

    function automatic int mask_of(int v);
        case (v)
            0: return 'h3F;
            1: return 'h06;
            2: return 'h5B;
            3: return 'h4F;
            4: return 'h66;
            5: return 'h6D;
            6: return 'h7D;
            7: return 'h07;
            8: return 'h7F;
            9: return 'h6F;
            default: return 0;
        endcase
    endfunction

    function automatic bit bar_lit(int lx, int ly, int m);
        if (((m >> 0) & 1) && ly < 16) return 1;
        if (((m >> 1) & 1) && lx >= 84 && ly < 80) return 1;
        if (((m >> 2) & 1) && lx >= 84 && ly >= 80) return 1;
        if (((m >> 3) & 1) && ly >= 144) return 1;
        if (((m >> 4) & 1) && lx < 16 && ly >= 80) return 1;
        if (((m >> 5) & 1) && lx < 16 && ly < 80) return 1;
        if (((m >> 6) & 1) && ly >= 72 && ly < 88) return 1;
        return 0;
    endfunction

    // returns 0 none, 1 lit digit, 2 blank-code cell
    function automatic int digit_state(int x, int y, int vals);
        for (int k = 0; k < 3; k++) begin
            int v  = (vals >> (4 * k)) & 15;
            int lx = x - 106 * k;
            int ly = y - 60;
            if (lx >= 0 && lx < 100 && ly >= 0 && ly < 160) begin
                if (v > 9) return 2;
                if (bar_lit(lx, ly, mask_of(v))) return 1;
            end
        end
        return 0;
    endfunction

    function automatic bit emblem_lit(int x, int y);
        int r;
        int c;
        if (x < 304 || x >= 336 || y < 432 || y >= 464) return 0;
        r = (y - 432) / 2;
        c = (x - 304) / 2;
        return ((r >> 2) & 1) == ((c >> 2) & 1);
    endfunction

    function automatic logic [11:0] model(int x, int y, int vals);
        if (x >= 640 || y >= 480) return 12'h000;
        if (digit_state(x, y, vals) == 1) return FG;
        if (emblem_lit(x, y)) return FG;
        return BG;
    endfunction

    function automatic string auto_tag(int x, int y, int vals);
        if (x >= 640 || y >= 480) return "R3";
        if (digit_state(x, y, vals) == 1) return "R4 R5 R7 R10";
        if (digit_state(x, y, vals) == 2) return "R6";
        if (emblem_lit(x, y)) return "R8";
        return "R9";
    endfunction

    task automatic compare(logic [11:0] exp, string tag);
        total++;
        if (rgb !== exp) begin
            bad++;
            $display("FAIL %s at t=%0t: rgb actual=%03h expected=%03h", tag, $time, rgb, exp);
        end
    endtask

    task automatic step(int x, int y, int vals, string tag);
        @(negedge clk);
        if (have_pend) compare(pend_exp, pend_tag);
        px_x      = 10'(x);
        px_y      = 10'(y);
        digit_val = 12'(vals);
        pend_exp  = model(x, y, vals);
        pend_tag  = (tag == "") ? auto_tag(x, y, vals) : tag;
        have_pend = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_pend) compare(pend_exp, pend_tag);
        have_pend = 0;
    endtask

    task automatic scan_digits(int vals);
        int rows[20] = '{59, 60, 61, 75, 76, 77, 100, 131, 132, 139,
                         140, 147, 148, 150, 180, 203, 204, 219, 220, 221};
        foreach (rows[i]) begin
            for (int x = 0; x < 316; x++) step(x, rows[i], vals, "");
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements): actual=still running expected=finished");
        summary();
    end

    initial begin
        // R1: reset holds the colour at zero even on a lit digit pixel
        px_x = 10'd50; px_y = 10'd65; digit_val = 12'h888;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            compare(12'h000, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: one-cycle latency, alternating lit and unlit pixels
        step(50, 65, 'h888, "R2");
        step(103, 65, 'h888, "R2");
        step(50, 65, 'h888, "R2");
        step(700, 65, 'h888, "R2");
        step(50, 65, 'h888, "R2");
        flush();

        // R4 R5 R7 R9 R10: bar geometry over several value patterns
        scan_digits('h210);
        scan_digits('h543);
        scan_digits('h876);
        scan_digits('h199);
        scan_digits('h888);
        scan_digits('h000);

        // R6: codes above nine, mixed with normal digits for R10
        scan_digits('hFDA);
        scan_digits('h1C1);

        // R8: emblem area with margins
        for (int y = 428; y < 469; y++) begin
            for (int x = 298; x < 342; x++) step(x, y, 'h888, "");
        end

        // R3: blanking past the active width and height
        for (int x = 620; x < 800; x++) step(x, 100, 'h888, "");
        for (int y = 470; y < 525; y++) step(50, y, 'h888, "");
        for (int y = 470; y < 525; y++) step(320, y, 'h888, "");
        flush();

        summary();
    end

endmodule